// File: doc/BRIEF.md
# Interleaved-Slot Shared Memory Bus Arbiter

This block decides, cycle by cycle, who may use a single memory bus that is shared between one processor and four direct-memory-access engines (bitplane display, sprite, audio and display-list fetch). Time on the bus is divided into slots that alternate between an even phase and an odd phase. Normally the processor uses the even slots and the engines take the odd ones, so neither side slows the other down.

When a real-time engine has already missed its odd slot and is still asking, the arbiter may give it the following even slot as well. The processor is then held in a wait state for that slot, and the event is counted. A stall-enable input turns this behaviour on or off. Processor accesses that decode outside the shared region go to memory private to the processor, so they never take part in arbitration. The size of the shared region is 512 KB, or 1 MB when a configuration input is set.

All grants are combinational from the current requests and the registered slot phase. The memory datapath uses the one-hot grants and an encoded select to steer its address multiplexer.

Top module: `smslot_arbiter`

## Requirements
- R1: The slot phase output `odd_slot` is 0 in the first cycle after reset is released and inverts on every following clock.
- R2: A processor request to the shared region is granted only in an even slot, and only when that slot is not stolen.
- R3: In an odd slot the requesting engine with the lowest index gets the grant: bitplane (0), then sprite (1), then audio (2), then display-list (3).
- R4: A real-time engine (0, 1 or 2) is backlogged when it asked in an odd slot without being granted and has kept asking since. In an even slot with `steal_en`=1 and any backlogged engine, the slot goes to the lowest-index real-time requester and the processor is not granted.
- R5: The display-list engine (3) is never granted in an even slot.
- R6: With `steal_en`=0, even slots are never given to an engine. A backlogged engine keeps requesting until an odd slot serves it.
- R7: `cpu_wait` is 1 exactly in a cycle where the processor requests the shared region and `cpu_gnt` is 0. It falls in the same cycle the grant arrives.
- R8: A processor request outside the shared region never raises `cpu_wait` or `cpu_gnt` and does not change any engine grant.
- R9: An address is in the shared region when it is below 0x80000 with `shared_1m`=0, or below 0x100000 with `shared_1m`=1.
- R10: At most one grant is active per cycle. `bus_sel` is 0 for no grant, 1 for the processor and 2+i for engine i.
- R11: `steal_count` resets to 0 and increases by one after each stolen even slot in which the processor was requesting the shared region.
- R12: While `rst_n` is low, no grant is active and `odd_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| steal_en | input | 1 | Allows engines to take even slots |
| shared_1m | input | 1 | Selects the 1 MB shared region instead of 512 KB |
| cpu_req | input | 1 | Processor access request |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_gnt | output | 1 | Processor owns the shared bus this cycle |
| cpu_wait | output | 1 | Processor must hold its shared access |
| dma_req | input | NUM_DMA | Per-engine requests, index 0 highest priority |
| dma_gnt | output | NUM_DMA | Per-engine one-hot grants |
| bus_sel | output | SEL_W | Encoded owner for the address multiplexer |
| odd_slot | output | 1 | Current slot phase, 1 for odd |
| steal_count | output | CNT_W | Number of processor slots taken by engines |

## Verification
If the phase register is wrong, the processor is granted in an odd slot or the engines are granted in the wrong phase, and this shows in the first cycle that carries a request. If the backlog flags are wrong, an even slot is stolen without cause or a due steal is missed. That shows up one slot after the missed odd slot, as a mismatch on `cpu_gnt`, `cpu_wait` and `dma_gnt`, and one clock later as a wrong `steal_count`. A scoreboard predicts every cycle's grant vector, select code, wait flag and count from the requirements, so any difference is reported in the cycle it happens.

// File: rtl/smslot_pkg.sv
package smslot_pkg;
    // bus_sel encoding
    localparam int unsigned SEL_NONE     = 0;
    localparam int unsigned SEL_CPU      = 1;
    localparam int unsigned SEL_DMA_BASE = 2;
    // engine indices, lowest index wins
    localparam int unsigned CH_BITPLANE  = 0;
    localparam int unsigned CH_SPRITE    = 1;
    localparam int unsigned CH_AUDIO     = 2;
    localparam int unsigned CH_DISPLIST  = 3;
    // shared region limits
    localparam int unsigned SHARED_LOG2_BASE = 19;
    localparam int unsigned SHARED_LOG2_EXT  = 20;
endpackage

// File: rtl/smslot_decode.sv
module smslot_decode #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext,
    output logic              in_shared
);
    import smslot_pkg::*;

    // the region must fit in the address width
    localparam logic [ADDR_W-1:0] LIMIT_BASE = ADDR_W'(1) << SHARED_LOG2_BASE;
    localparam logic [ADDR_W-1:0] LIMIT_EXT  = ADDR_W'(1) << SHARED_LOG2_EXT;

    always_comb begin
        in_shared = ext ? (addr < LIMIT_EXT) : (addr < LIMIT_BASE);
    end
endmodule

// File: rtl/smslot_prio.sv
module smslot_prio #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]     = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end
endmodule

// File: rtl/smslot_arbiter.sv
module smslot_arbiter #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned NUM_DMA = 4,
    parameter logic [NUM_DMA-1:0] RT_MASK = {NUM_DMA{1'b1}} >> 1,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned SEL_W = $clog2(NUM_DMA + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               steal_en,
    input  logic               shared_1m,
    input  logic               cpu_req,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               cpu_gnt,
    output logic               cpu_wait,
    input  logic [NUM_DMA-1:0] dma_req,
    output logic [NUM_DMA-1:0] dma_gnt,
    output logic [SEL_W-1:0]   bus_sel,
    output logic               odd_slot,
    output logic [CNT_W-1:0]   steal_count
);
    import smslot_pkg::*;

    typedef struct packed {
        logic               slot_odd;
        logic [NUM_DMA-1:0] waited;
        logic [CNT_W-1:0]   steals;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic               addr_shared;
    logic               cpu_shared_req;
    logic [NUM_DMA-1:0] pick_all;
    logic [NUM_DMA-1:0] pick_rt;
    logic               backlog;
    logic               steal_now;
    logic               cpu_gnt_c;
    logic [NUM_DMA-1:0] dma_gnt_c;
    logic [SEL_W-1:0]   sel_c;

    smslot_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (cpu_addr),
        .ext       (shared_1m),
        .in_shared (addr_shared)
    );

    smslot_prio #(.N(NUM_DMA)) u_pick_all (
        .req (dma_req),
        .gnt (pick_all)
    );

    smslot_prio #(.N(NUM_DMA)) u_pick_rt (
        .req (dma_req & RT_MASK),
        .gnt (pick_rt)
    );

    // grant selection and next state
    always_comb begin
        cpu_shared_req = cpu_req & addr_shared;
        backlog        = |(st_q.waited & dma_req & RT_MASK);
        steal_now      = rst_n & ~st_q.slot_odd & steal_en & backlog;

        cpu_gnt_c = 1'b0;
        dma_gnt_c = '0;
        if (rst_n) begin
            if (st_q.slot_odd) begin
                dma_gnt_c = pick_all;
            end else if (steal_now) begin
                dma_gnt_c = pick_rt;
            end else begin
                cpu_gnt_c = cpu_shared_req;
            end
        end

        sel_c = SEL_W'(SEL_NONE);
        if (cpu_gnt_c) begin
            sel_c = SEL_W'(SEL_CPU);
        end
        for (int i = 0; i < NUM_DMA; i++) begin
            if (dma_gnt_c[i]) begin
                sel_c = SEL_W'(SEL_DMA_BASE + i);
            end
        end

        st_d.slot_odd = ~st_q.slot_odd;
        for (int i = 0; i < NUM_DMA; i++) begin
            st_d.waited[i] = dma_req[i] & ~dma_gnt_c[i] &
                             (st_q.waited[i] | st_q.slot_odd);
        end
        st_d.steals = st_q.steals;
        if (steal_now && cpu_shared_req) begin
            st_d.steals = st_q.steals + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_gnt     = cpu_gnt_c;
    assign cpu_wait    = cpu_shared_req & ~cpu_gnt_c;
    assign dma_gnt     = dma_gnt_c;
    assign bus_sel     = sel_c;
    assign odd_slot    = st_q.slot_odd;
    assign steal_count = st_q.steals;

    // checks next to the logic they guard
    AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (odd_slot != $past(odd_slot)));                  // R1
    AST_CPU_EVEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> !odd_slot);                                            // R2
    AST_LIST_NO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !odd_slot |-> !dma_gnt[CH_DISPLIST]);                              // R5
    AST_NO_STEAL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!odd_slot && !steal_en) |-> (dma_gnt == '0));                     // R6
    AST_PRIVATE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !addr_shared) |-> (!cpu_wait && !cpu_gnt));            // R8
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, dma_gnt}));                                     // R10
    AST_COUNT_HOLDS_ON_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |=> $stable(steal_count));                                 // R11
endmodule

// File: tb/smslot_arbiter_bench.sv
module smslot_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        steal_en = 1'b0;
    logic        shared_1m = 1'b0;
    logic        cpu_req = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_gnt;
    logic        cpu_wait;
    logic [3:0]  dma_req = '0;
    logic [3:0]  dma_gnt;
    logic [2:0]  bus_sel;
    logic        odd_slot;
    logic [15:0] steal_count;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smslot_arbiter u_smslot_arbiter (
        .clk(clk), .rst_n(rst_n), .steal_en(steal_en), .shared_1m(shared_1m),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_gnt(cpu_gnt),
        .cpu_wait(cpu_wait), .dma_req(dma_req), .dma_gnt(dma_gnt),
        .bus_sel(bus_sel), .odd_slot(odd_slot), .steal_count(steal_count)
    );

    typedef struct {
        logic        cg;
        logic        cw;
        logic        odd;
        logic [3:0]  dg;
        logic [2:0]  sel;
        logic [15:0] cnt;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // bench model state
    logic        m_odd;
    logic [3:0]  m_wait;
    logic [15:0] m_cnt;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] lowest(input logic [3:0] r);
        for (int i = 0; i < 4; i++) if (r[i]) return 4'b0001 << i;
        return 4'b0000;
    endfunction

    // driver: applies one cycle of stimulus and pushes the prediction
    task automatic drive(input string tag, input logic creq, input logic [23:0] addr,
                         input logic [3:0] dreq, input logic sen, input logic ext);
        exp_t e;
        logic shared, cs, stolen;
        @(negedge clk);
        cpu_req = creq; cpu_addr = addr; dma_req = dreq;
        steal_en = sen; shared_1m = ext;
        shared = ext ? (addr < 24'h100000) : (addr < 24'h080000);
        cs = creq & shared;
        stolen = 1'b0;
        e.cg = 1'b0; e.dg = 4'b0;
        if (m_odd) begin
            e.dg = lowest(dreq);
        end else if (sen && |(m_wait & dreq & 4'b0111)) begin
            e.dg = lowest(dreq & 4'b0111);
            stolen = 1'b1;
        end else begin
            e.cg = cs;
        end
        e.cw  = cs & ~e.cg;
        e.odd = m_odd;
        e.cnt = m_cnt;
        e.sel = e.cg ? 3'd1 : 3'd0;
        for (int i = 0; i < 4; i++) if (e.dg[i]) e.sel = 3'(2 + i);
        e.tag = tag;
        sb.push_back(e);
        if (stolen && cs) m_cnt = m_cnt + 16'd1;
        for (int i = 0; i < 4; i++) m_wait[i] = dreq[i] & ~e.dg[i] & (m_wait[i] | m_odd);
        m_odd = ~m_odd;
    endtask

    // monitor: compares outputs late in the low phase
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk("R1",  {e.tag, " odd_slot"}, 32'(odd_slot), 32'(e.odd));
                chk("R2/R3/R4/R6", {e.tag, " cpu_gnt"}, 32'(cpu_gnt), 32'(e.cg));
                chk("R3/R4/R5", {e.tag, " dma_gnt"}, 32'(dma_gnt), 32'(e.dg));
                chk("R7/R8", {e.tag, " cpu_wait"}, 32'(cpu_wait), 32'(e.cw));
                chk("R10", {e.tag, " bus_sel"}, 32'(bus_sel), 32'(e.sel));
                chk("R11", {e.tag, " steal_count"}, 32'(steal_count), 32'(e.cnt));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R12: reset holds grants off even with requests present
        cpu_req = 1'b1; cpu_addr = 24'h000100; dma_req = 4'b1111; steal_en = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk("R12", "reset cpu_gnt", 32'(cpu_gnt), 0);
        chk("R12", "reset dma_gnt", 32'(dma_gnt), 0);
        chk("R12", "reset odd_slot", 32'(odd_slot), 0);
        chk("R11", "reset steal_count", 32'(steal_count), 0);
        cpu_req = 1'b0; dma_req = 4'b0; steal_en = 1'b0;
        rst_n = 1'b1;
        chk("R1", "first slot even", 32'(odd_slot), 0);
        // first cycle after release is idle and even
        m_odd = 1'b1; m_wait = '0; m_cnt = '0;

        // R2 R7: processor alone gets even slots, waits on odd
        for (int i = 0; i < 4; i++) drive("cpu_alone", 1, 24'h001000, 4'b0000, 1, 0);
        // R3: odd-slot priority under several request patterns
        drive("prio_all",   1, 24'h000200, 4'b1111, 0, 0);
        drive("prio_all",   1, 24'h000200, 4'b1110, 0, 0);
        drive("prio_hi",    1, 24'h000200, 4'b1100, 0, 0);
        drive("prio_hi",    1, 24'h000200, 4'b1000, 0, 0);
        drive("prio_mid",   0, 24'h000000, 4'b0000, 0, 0);
        drive("prio_mid",   0, 24'h000000, 4'b0110, 0, 0);
        // R6: backlog exists but stealing disabled
        for (int i = 0; i < 6; i++) drive("no_steal", 1, 24'h004000, 4'b0011, 0, 0);
        // R4 R11: backlog with stealing enabled
        for (int i = 0; i < 8; i++) drive("steal", 1, 24'h004000, 4'b0110, 1, 0);
        for (int i = 0; i < 4; i++) drive("steal_cpu_idle", 0, 24'h000000, 4'b0101, 1, 0);
        // R5: display-list backlog never takes an even slot
        for (int i = 0; i < 6; i++) drive("list_only", 1, 24'h000040, 4'b1000, 1, 0);
        // R8: private accesses under heavy engine load
        for (int i = 0; i < 6; i++) drive("private", 1, 24'h200000, 4'b0111, 1, 0);
        // R9: region boundary, both sizes
        drive("bound512_in",  1, 24'h07FFFF, 4'b0000, 1, 0);
        drive("bound512_in",  1, 24'h07FFFF, 4'b0000, 1, 0);
        drive("bound512_out", 1, 24'h080000, 4'b0000, 1, 0);
        drive("bound512_out", 1, 24'h080000, 4'b0000, 1, 0);
        drive("bound1m_in",   1, 24'h080000, 4'b0000, 1, 1);
        drive("bound1m_in",   1, 24'h0FFFFF, 4'b0000, 1, 1);
        drive("bound1m_out",  1, 24'h100000, 4'b0000, 1, 1);
        drive("bound1m_out",  1, 24'h100000, 4'b0000, 1, 1);
        // mixed pattern with steals in the larger region
        for (int i = 0; i < 10; i++)
            drive("mixed", 1, 24'h0C0000, (i % 3 == 0) ? 4'b0001 : 4'b1100, 1, 1);
        drive("idle", 0, 24'h000000, 4'b0000, 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule